// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block sits beside a program sequencer and runs hardware loops without any branch instructions. It handles one single-instruction repeat and two nested block-repeat levels (outer level 0 and inner level 1). Software or the decode stage writes the loop registers through one load port: a computed repeat count, and for each block level a count, a first address and a last address. Command pulses then start a single repeat or a block level. A count of N always means N+1 executions.

Every time an instruction completes, the controller compares its address with the last address of each active block. If a level's count is nonzero, the count drops by one and the fetch unit is sent back to the first address of the block. If the count is zero, the level goes idle and execution falls through. While a single repeat still has executions to go, the controller holds the PC so that the same instruction issues again. The inner level keeps a save copy of its count, so that each time the outer loop reaches the inner start command, the inner loop starts over with its full count.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, all three busy flags, `hold_o` and `redirect_o` are low.
- R2: A load with `ld_en_i` high writes `ld_data_i` into the register picked by `ld_sel_i`. The codes are: 0 computed repeat count, 1 outer count, 2 outer first address, 3 outer last address, 4 inner count, 5 inner first address, 6 inner last address. Code 7 writes nothing.
- R3: A pulse on `rpt_go_i` copies the computed repeat count N into the repeat counter and sets `rpt_busy_o`. `hold_o` stays high for exactly N completions, and `rpt_busy_o` drops after completion N+1.
- R4: With a computed count of 0, a single repeat never raises `hold_o`, and it ends after one completion.
- R5: When an active block level completes its last-address instruction and its count is nonzero, `redirect_o` is high in that cycle, `target_o` equals the level's first address, and the count drops by one. A count of N gives N+1 passes.
- R6: When a level's count is zero and its last-address instruction completes, the level goes idle and `redirect_o` stays low.
- R7: A cycle with `done_i` low, or a completion at any other address, neither redirects nor changes any loop state.
- R8: A load into the inner count also writes the inner save register. Each `blk1_go_i` pulse reloads the inner count from the save register.
- R9: When both levels end on the same address, the inner level is handled first. The outer level acts on that completion only if the inner level falls through.
- R10: While `hold_o` is high, no block redirect occurs. The block-end check applies to the final execution of a repeated instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | AW | Address of the instruction now completing |
| done_i | input | 1 | Instruction completes this cycle |
| rpt_go_i | input | 1 | Start a single repeat |
| blk0_go_i | input | 1 | Start the outer block level |
| blk1_go_i | input | 1 | Start or restart the inner block level |
| ld_en_i | input | 1 | Register load strobe |
| ld_sel_i | input | 3 | Register select code (see R2) |
| ld_data_i | input | max(AW,CW) | Load value |
| redirect_o | output | 1 | Fetch must jump to `target_o` |
| target_o | output | AW | Redirect address, zero when no redirect |
| hold_o | output | 1 | Fetch must reissue the same PC |
| rpt_busy_o | output | 1 | Single repeat in progress |
| blk0_busy_o | output | 1 | Outer level active |
| blk1_busy_o | output | 1 | Inner level active |

## Verification
A wrong count or a lost save value does not show up right away. It becomes visible only at the next pass over a block end, as a redirect that fires once too often or once too few, or as a busy flag that drops early. For this reason the bench runs whole nested loops with a PC driven by a model and compares every output on every cycle. It also counts how often the last address of each loop executes. A priority fault between the inner level, the outer level and the single repeat shows at the shared address in the same cycle, as a wrong target or as a redirect while `hold_o` is high.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [2:0] {
    SEL_RPT_CNT = 3'd0,
    SEL_CNT0    = 3'd1,
    SEL_BEG0    = 3'd2,
    SEL_END0    = 3'd3,
    SEL_CNT1    = 3'd4,
    SEL_BEG1    = 3'd5,
    SEL_END1    = 3'd6,
    SEL_NONE    = 3'd7
  } ld_sel_e;
endpackage

// File: rtl/zol_rpt.sv
module zol_rpt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_we,
  input  logic [CW-1:0] wdata,
  input  logic          start_i,
  input  logic          done_i,
  output logic          busy_o,
  output logic          hold_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] comp_q, comp_d, cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    comp_d = comp_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (cnt_we) comp_d = wdata;
    if (start_i) begin
      cnt_d  = comp_q;
      busy_d = 1'b1;
    end else if (busy_q && done_i) begin
      if (cnt_q != '0) cnt_d = cnt_q - ONE;
      else             busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      comp_q <= comp_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign hold_o = busy_q && (cnt_q != '0);

  // R3: the final execution ends the repeat
  p_last_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i && !hold_o && !start_i) |=> !busy_q);
  // R4: a zero count never holds the PC
  p_zero_nohold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && comp_q == '0 && !cnt_we) |=> !hold_o);
endmodule

// File: rtl/zol_level.sv
module zol_level #(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter bit HAS_SAVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_we,
  input  logic          beg_we,
  input  logic          end_we,
  input  logic [CW-1:0] wcnt,
  input  logic [AW-1:0] waddr,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [AW-1:0] pc_i,
  output logic          act_o,
  output logic          hit_o,
  output logic          last_o,
  output logic [AW-1:0] beg_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d, reload;
  logic [AW-1:0] beg_q, beg_d, end_q, end_d;
  logic          act_q, act_d;

  generate
    if (HAS_SAVE) begin : g_save
      logic [CW-1:0] save_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      save_q <= '0;
        else if (cnt_we) save_q <= wcnt;
      end
      assign reload = save_q;
      // R8: every count load is mirrored into the save copy
      p_save_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (save_q == $past(wcnt)));
    end else begin : g_nosave
      assign reload = cnt_q;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    beg_d = beg_q;
    end_d = end_q;
    act_d = act_q;
    if (beg_we) beg_d = waddr;
    if (end_we) end_d = waddr;
    if (cnt_we) begin
      cnt_d = wcnt;
      if (start_i) act_d = 1'b1;
    end else if (start_i) begin
      cnt_d = reload;
      act_d = 1'b1;
    end else if (step_i) begin
      if (cnt_q != '0) cnt_d = cnt_q - ONE;
      else             act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      beg_q <= '0;
      end_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      beg_q <= beg_d;
      end_q <= end_d;
      act_q <= act_d;
    end
  end

  assign act_o  = act_q;
  assign hit_o  = act_q && (pc_i == end_q);
  assign last_o = (cnt_q == '0);
  assign beg_o  = beg_q;

  // R6: an exhausted level leaves when its end completes
  p_zero_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && last_o && !start_i && !cnt_we) |=> !act_q);
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [AW-1:0]                  pc_i,
  input  logic                           done_i,
  input  logic                           rpt_go_i,
  input  logic                           blk0_go_i,
  input  logic                           blk1_go_i,
  input  logic                           ld_en_i,
  input  logic [2:0]                     ld_sel_i,
  input  logic [((AW>CW)?AW:CW)-1:0]     ld_data_i,
  output logic                           redirect_o,
  output logic [AW-1:0]                  target_o,
  output logic                           hold_o,
  output logic                           rpt_busy_o,
  output logic                           blk0_busy_o,
  output logic                           blk1_busy_o
);
  import zol_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ld_sel_e       sel;
  logic [CW-1:0] wcnt;
  logic [AW-1:0] waddr;
  logic we_rpt, we_c0, we_b0, we_e0, we_c1, we_b1, we_e1;

  always_comb begin
    sel    = ld_sel_e'(ld_sel_i);
    we_rpt = ld_en_i && (sel == SEL_RPT_CNT);
    we_c0  = ld_en_i && (sel == SEL_CNT0);
    we_b0  = ld_en_i && (sel == SEL_BEG0);
    we_e0  = ld_en_i && (sel == SEL_END0);
    we_c1  = ld_en_i && (sel == SEL_CNT1);
    we_b1  = ld_en_i && (sel == SEL_BEG1);
    we_e1  = ld_en_i && (sel == SEL_END1);
  end
  assign wcnt  = ld_data_i[CW-1:0];
  assign waddr = ld_data_i[AW-1:0];

  logic hold, rpt_busy;
  logic act0, hit0, last0, act1, hit1, last1;
  logic [AW-1:0] beg0, beg1;
  logic eval, take1, take0, step0, step1;

  zol_rpt #(.CW(CW)) u_rpt (
    .clk(clk), .rst_n(rst_core_n), .cnt_we(we_rpt), .wdata(wcnt),
    .start_i(rpt_go_i), .done_i(done_i), .busy_o(rpt_busy), .hold_o(hold)
  );

  // evaluation order: hold, then inner level, then outer level
  always_comb begin
    eval  = done_i && !hold;
    step1 = eval && hit1;
    take1 = step1 && !last1;
    step0 = eval && hit0 && !take1;
    take0 = step0 && !last0;
  end

  zol_level #(.AW(AW), .CW(CW), .HAS_SAVE(1'b0)) u_lvl0 (
    .clk(clk), .rst_n(rst_core_n), .cnt_we(we_c0), .beg_we(we_b0),
    .end_we(we_e0), .wcnt(wcnt), .waddr(waddr), .start_i(blk0_go_i),
    .step_i(step0), .pc_i(pc_i), .act_o(act0), .hit_o(hit0),
    .last_o(last0), .beg_o(beg0)
  );

  zol_level #(.AW(AW), .CW(CW), .HAS_SAVE(1'b1)) u_lvl1 (
    .clk(clk), .rst_n(rst_core_n), .cnt_we(we_c1), .beg_we(we_b1),
    .end_we(we_e1), .wcnt(wcnt), .waddr(waddr), .start_i(blk1_go_i),
    .step_i(step1), .pc_i(pc_i), .act_o(act1), .hit_o(hit1),
    .last_o(last1), .beg_o(beg1)
  );

  always_comb begin
    redirect_o = take1 || take0;
    if (take1)      target_o = beg1;
    else if (take0) target_o = beg0;
    else            target_o = '0;
  end

  assign hold_o      = hold;
  assign rpt_busy_o  = rpt_busy;
  assign blk0_busy_o = act0;
  assign blk1_busy_o = act1;

  // R10: a held PC is never redirected
  p_hold_excl_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    hold_o |-> !redirect_o);
  // R7: redirects happen only on a completion
  p_redir_done_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    redirect_o |-> done_i);
  // R9: inner level wins a shared end address
  p_inner_first_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (take1 && hit0) |-> (target_o == beg1));
endmodule

// File: tb/sim_zol_ctrl.sv
module sim_zol_ctrl;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic done_i = 1'b0, rpt_go_i = 1'b0, blk0_go_i = 1'b0, blk1_go_i = 1'b0;
  logic ld_en_i = 1'b0;
  logic [2:0] ld_sel_i = 3'd7;
  logic [15:0] ld_data_i = '0;
  logic redirect_o, hold_o, rpt_busy_o, blk0_busy_o, blk1_busy_o;
  logic [AW-1:0] target_o;

  always #5 clk = ~clk;

  zol_ctrl #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .done_i(done_i),
    .rpt_go_i(rpt_go_i), .blk0_go_i(blk0_go_i), .blk1_go_i(blk1_go_i),
    .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
    .redirect_o(redirect_o), .target_o(target_o), .hold_o(hold_o),
    .rpt_busy_o(rpt_busy_o), .blk0_busy_o(blk0_busy_o), .blk1_busy_o(blk1_busy_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  int m_csr = 0, m_rc = 0; bit m_ra = 0;
  int m_c[2] = '{0, 0}, m_s[2] = '{0, 0}, m_e[2] = '{0, 0};
  bit m_a[2] = '{0, 0};
  int m_save = 0;
  bit e_redir, e_hold; int e_tgt;

  function automatic void predict(int pc, bit dn);
    bit inner_done;
    e_hold  = m_ra && (m_rc > 0);
    e_redir = 0; e_tgt = 0;
    if (dn && !e_hold) begin
      inner_done = 0;
      if (m_a[1] && pc == m_e[1]) begin
        if (m_c[1] > 0) begin e_redir = 1; e_tgt = m_s[1]; end
        else inner_done = 1;
      end
      if (!e_redir && m_a[0] && pc == m_e[0] && m_c[0] > 0) begin
        e_redir = 1; e_tgt = m_s[0];
      end
      if (inner_done) e_redir = e_redir; // inner exhausted falls to outer
    end
  endfunction

  function automatic void advance(int pc, bit dn, bit rs, bit s0, bit s1,
                                  bit le, int sel, int dat);
    bit used1;
    used1 = 0;
    if (dn && !e_hold) begin
      if (m_a[1] && pc == m_e[1] && !s1) begin
        if (m_c[1] > 0) begin m_c[1]--; used1 = 1; end
        else m_a[1] = 0;
      end else if (m_a[1] && pc == m_e[1] && m_c[1] > 0) used1 = 1;
      if (!used1 && m_a[0] && pc == m_e[0] && !s0) begin
        if (m_c[0] > 0) m_c[0]--; else m_a[0] = 0;
      end
    end
    if (rs) begin m_rc = m_csr; m_ra = 1; end
    else if (m_ra && dn) begin
      if (m_rc > 0) m_rc--; else m_ra = 0;
    end
    if (s0) m_a[0] = 1;
    if (s1) begin m_a[1] = 1; m_c[1] = m_save; end
    if (le) case (sel)
      0: m_csr = dat;
      1: m_c[0] = dat;
      2: m_s[0] = dat;
      3: m_e[0] = dat;
      4: begin m_c[1] = dat; m_save = dat; end
      5: m_s[1] = dat;
      6: m_e[1] = dat;
      default: ;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(int pc, bit dn, bit rs, bit s0, bit s1,
                      bit le, int sel, int dat, string tag);
    int gv, ev;
    @(negedge clk);
    pc_i = pc[AW-1:0]; done_i = dn; rpt_go_i = rs; blk0_go_i = s0;
    blk1_go_i = s1; ld_en_i = le; ld_sel_i = sel[2:0]; ld_data_i = dat[15:0];
    #1;
    predict(pc, dn);
    gv = {redirect_o ? int'(target_o) : 0, 1'b0, redirect_o, hold_o,
          rpt_busy_o, blk0_busy_o, blk1_busy_o};
    ev = {e_redir ? e_tgt : 0, 1'b0, e_redir, e_hold, m_ra, m_a[0], m_a[1]};
    chk(gv == ev, tag, "outputs{tgt,redir,hold,rpt,b0,b1}", gv, ev);
    @(posedge clk);
    advance(pc, dn, rs, s0, s1, le, sel, dat);
  endtask

  task automatic ld(int sel, int dat, string tag);
    step(0, 0, 0, 0, 0, 1, sel, dat, tag);
  endtask

  // PC follows the model; returns how many times watch_pc completed
  task automatic run(int pc0, int stop_pc, int rpt_at, int b1_at,
                     int watch_pc, output int hits, input string tag);
    int pc;
    pc = pc0; hits = 0;
    for (int i = 0; i < 400 && pc != stop_pc; i++) begin
      step(pc, 1, pc == rpt_at, 0, pc == b1_at, 0, 7, 0, tag);
      if (pc == watch_pc) hits++;
      if (e_redir) pc = e_tgt;
      else if (!e_hold) pc = pc + 1;
    end
    chk(pc == stop_pc, tag, "exit pc", pc, stop_pc);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h;
    // R1: reset state
    step(0, 1, 0, 0, 0, 0, 7, 0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 7, 0, "R1");

    // R3: single repeat with computed count 3 -> 4 executions
    ld(0, 3, "R2");
    step(9, 1, 1, 0, 0, 0, 7, 0, "R3");
    run(10, 11, -1, -1, 10, h, "R3");
    chk(h == 4, "R3", "repeat executions", h, 4);

    // R4: count zero -> one execution, no hold
    ld(0, 0, "R4");
    step(9, 1, 1, 0, 0, 0, 7, 0, "R4");
    run(10, 11, -1, -1, 10, h, "R4");
    chk(h == 1, "R4", "repeat executions", h, 1);

    // R5/R7: outer block 20..23, count 2
    ld(2, 20, "R2"); ld(3, 23, "R2"); ld(1, 2, "R2");
    step(23, 1, 0, 0, 0, 0, 7, 0, "R7");          // not active yet
    step(19, 1, 0, 1, 0, 0, 7, 0, "R5");
    step(23, 0, 0, 0, 0, 0, 7, 0, "R7");          // no completion
    step(22, 1, 0, 0, 0, 0, 7, 0, "R7");          // other address
    ld(7, 99, "R2");                              // code 7 writes nothing
    run(20, 24, -1, -1, 23, h, "R5");
    chk(h == 3, "R5", "block passes", h, 3);
    step(23, 1, 0, 0, 0, 0, 7, 0, "R6");          // idle level ignores end

    // R8: nested, outer 40..50 count 1, inner 42..45 count 2
    ld(2, 40, "R8"); ld(3, 50, "R8"); ld(1, 1, "R8");
    ld(5, 42, "R8"); ld(6, 45, "R8"); ld(4, 2, "R8");
    step(39, 1, 0, 1, 0, 0, 7, 0, "R8");
    run(40, 51, -1, 41, 45, h, "R8");
    chk(h == 6, "R8", "inner end executions", h, 6);

    // R9: shared end 75, outer 70 count 1, inner 72 count 1
    ld(2, 70, "R9"); ld(3, 75, "R9"); ld(1, 1, "R9");
    ld(5, 72, "R9"); ld(6, 75, "R9"); ld(4, 1, "R9");
    step(69, 1, 0, 1, 0, 0, 7, 0, "R9");
    run(70, 76, -1, 71, 75, h, "R9");
    chk(h == 4, "R9", "shared end executions", h, 4);

    // R10: repeat of the block's last instruction, csr 2, outer 80..83 count 1
    ld(0, 2, "R10"); ld(2, 80, "R10"); ld(3, 83, "R10"); ld(1, 1, "R10");
    step(79, 1, 0, 1, 0, 0, 7, 0, "R10");
    run(80, 84, 82, -1, 83, h, "R10");
    chk(h == 6, "R10", "repeated end executions", h, 6);

    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 0, 7, 0, "R6");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule